// File: doc/BRIEF.md
# Infrared Remote Frame Encoder

This block turns an 8-bit device address and an 8-bit key code into the pulse train of a consumer infrared remote control. A request from the host logic captures both bytes. The block then sends a long leader burst and a silent gap. It follows with 32 data bits and closes with one short burst. While a burst is active, the LED drive is chopped by a carrier near 38 kHz. Between bursts the LED stays dark. Each bit is coded by the length of the silence that follows a fixed short burst. The 32 bits carry each byte once as it is and once inverted, so a receiver can reject corrupted frames.

A second request sends the short "key still held" frame. That frame has a leader burst, a shorter gap and a single closing burst, and it carries no data. All timing is counted in ticks of TICK_US microseconds. A divider derives the tick from the system clock frequency given as a parameter, and the carrier period comes from the same clock. An unmodulated envelope output is high exactly during bursts, so the timing can be checked without the carrier. A busy flag covers the whole frame.

Top module: `nec_ir_tx`

## Requirements
- R1: While and right after reset, `led_out`, `env_out` and `busy` are all 0.
- R2: When idle, a `start_req` sampled high on a clock edge captures `addr_in` and `cmd_in`. `busy` and `env_out` go high after that edge. The leader is a burst of 900 ticks followed by a gap of 450 ticks. One tick is TICK_US µs, which is CLK_HZ*TICK_US/1e6 clock cycles, and every burst and gap lasts an exact whole number of ticks.
- R3: The 32 data bits go out as address, inverted address, command, inverted command. Each byte goes least significant bit first.
- R4: Every data bit is a 56-tick burst. After it comes a 56-tick gap for a 0 or a 169-tick gap for a 1.
- R5: After the 32nd bit gap comes a 56-tick closing burst. `busy` falls on the same edge where that burst ends.
- R6: When idle with `start_req` low, a `repeat_req` sampled high sends a 900-tick burst, a 225-tick gap and a 56-tick burst, with no data bits.
- R7: When `start_req` and `repeat_req` are both high while idle, the full data frame is sent.
- R8: `start_req` and `repeat_req` have no effect while `busy` is high. The frame in flight keeps its captured bytes, and no extra frame follows it.
- R9: During a burst, `led_out` is high for the first CAR_HIGH cycles of each CAR_DIV-cycle carrier period. CAR_DIV is CLK_HZ/CARRIER_HZ and CAR_HIGH is CAR_DIV/3 (at least 1). The period count restarts at the first cycle of every burst. `led_out` is 0 whenever `env_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request a full data frame |
| repeat_req | input | 1 | Request a repeat frame |
| addr_in | input | 8 | Device address captured on an accepted start |
| cmd_in | input | 8 | Key code captured on an accepted start |
| led_out | output | 1 | Carrier-modulated LED drive |
| env_out | output | 1 | Unmodulated burst envelope |
| busy | output | 1 | High from the cycle after acceptance until the closing burst ends |

## Verification
The full frame is sent with all-zero and all-ones bytes, with alternating and one-hot patterns, and with mixed patterns. Every bit gap therefore appears in both lengths in every byte position, and a swapped byte order, a missing inversion or a reversed bit order shows up as a gap of the wrong length at a known bit index. The repeat request is tried alone and together with a start request. The leader gap length (225 versus 450 ticks) tells which request won. During one frame both requests are pulsed with other bytes. The frame must stay unchanged, and the envelope must stay low afterwards. The LED is compared cycle by cycle against the carrier phase counted from the start of each burst.

// File: rtl/nec_tx_pkg.sv
package nec_tx_pkg;

    // Segment lengths in timing ticks
    localparam int T_LEAD_MARK  = 900;
    localparam int T_LEAD_SPACE = 450;
    localparam int T_REP_SPACE  = 225;
    localparam int T_BIT_MARK   = 56;
    localparam int T_ZERO_SPACE = 56;
    localparam int T_ONE_SPACE  = 169;
    localparam int T_STOP_MARK  = 56;

    localparam int NUM_BITS = 32;
    localparam int BIT_W    = $clog2(NUM_BITS);
    localparam int SEG_W    = $clog2(T_LEAD_MARK + 1);

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_LEAD_MARK,
        TX_LEAD_SPACE,
        TX_REP_SPACE,
        TX_BIT_MARK,
        TX_BIT_SPACE,
        TX_STOP_MARK
    } tx_state_e;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] cmd;
    } nec_payload_t;

    // Transmit word, bit 0 leaves first
    function automatic logic [NUM_BITS-1:0] build_word(input nec_payload_t p);
        return {~p.cmd, p.cmd, ~p.addr, p.addr};
    endfunction

    function automatic logic is_mark(input tx_state_e s);
        return (s == TX_LEAD_MARK) || (s == TX_BIT_MARK) || (s == TX_STOP_MARK);
    endfunction

    function automatic logic [SEG_W-1:0] seg_len(input int ticks);
        return SEG_W'(ticks);
    endfunction

endpackage

// File: rtl/nec_tick_gen.sv
module nec_tick_gen #(
    parameter int DIV = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);

            // Every frame starts its first tick period from a cleared count
            assert_tick_phase_R2: assert property (@(posedge clk) disable iff (rst)
                $rose(run) |-> (cnt == '0));
        end else begin : g_pass
            assign tick = run;
        end
    endgenerate

endmodule

// File: rtl/nec_carrier_gen.sv
module nec_carrier_gen #(
    parameter int PERIOD = 1315,
    parameter int HIGH   = 438
) (
    input  logic clk,
    input  logic rst,
    input  logic env,
    output logic led
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HIGH_V = CW'(HIGH);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !env) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign led = env && (phase < HIGH_V);

    // Carrier phase restarts at each burst
    assert_carrier_restart_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(env) |-> (phase == '0));

    assert_led_dark_R9: assert property (@(posedge clk) disable iff (rst)
        !env |-> !led);

endmodule

// File: rtl/nec_frame_seq.sv
module nec_frame_seq
    import nec_tx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         start_req,
    input  logic         repeat_req,
    input  nec_payload_t payload,
    output logic         env,
    output logic         busy
);
    tx_state_e             state;
    logic [SEG_W-1:0]      seg_left;
    logic [BIT_W-1:0]      bit_idx;
    logic [NUM_BITS-1:0]   word_q;
    logic                  rep_mode;
    logic                  seg_done;

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NUM_BITS - 1);

    assign seg_done = tick && (seg_left == seg_len(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            seg_left <= '0;
            bit_idx  <= '0;
            word_q   <= '0;
            rep_mode <= 1'b0;
        end else if (state == TX_IDLE) begin
            if (start_req) begin
                word_q   <= build_word(payload);
                rep_mode <= 1'b0;
                bit_idx  <= '0;
                state    <= TX_LEAD_MARK;
                seg_left <= seg_len(T_LEAD_MARK);
            end else if (repeat_req) begin
                rep_mode <= 1'b1;
                bit_idx  <= '0;
                state    <= TX_LEAD_MARK;
                seg_left <= seg_len(T_LEAD_MARK);
            end
        end else if (seg_done) begin
            case (state)
                TX_LEAD_MARK: begin
                    if (rep_mode) begin
                        state    <= TX_REP_SPACE;
                        seg_left <= seg_len(T_REP_SPACE);
                    end else begin
                        state    <= TX_LEAD_SPACE;
                        seg_left <= seg_len(T_LEAD_SPACE);
                    end
                end
                TX_LEAD_SPACE: begin
                    state    <= TX_BIT_MARK;
                    seg_left <= seg_len(T_BIT_MARK);
                end
                TX_BIT_MARK: begin
                    state    <= TX_BIT_SPACE;
                    seg_left <= word_q[bit_idx] ? seg_len(T_ONE_SPACE)
                                                : seg_len(T_ZERO_SPACE);
                end
                TX_BIT_SPACE: begin
                    if (bit_idx == LAST_BIT) begin
                        state    <= TX_STOP_MARK;
                        seg_left <= seg_len(T_STOP_MARK);
                    end else begin
                        bit_idx  <= bit_idx + 1'b1;
                        state    <= TX_BIT_MARK;
                        seg_left <= seg_len(T_BIT_MARK);
                    end
                end
                TX_REP_SPACE: begin
                    state    <= TX_STOP_MARK;
                    seg_left <= seg_len(T_STOP_MARK);
                end
                TX_STOP_MARK: begin
                    state    <= TX_IDLE;
                    seg_left <= '0;
                end
                default: begin
                    state    <= TX_IDLE;
                    seg_left <= '0;
                end
            endcase
        end else if (tick) begin
            seg_left <= seg_left - 1'b1;
        end
    end

    assign env  = is_mark(state);
    assign busy = (state != TX_IDLE);

    // Captured bytes never change inside a frame
    assert_hold_payload_R8: assert property (@(posedge clk) disable iff (rst)
        (state != TX_IDLE) |=> $stable(word_q));

    // An accepted request always opens with a full-length leader burst
    assert_leader_load_R2: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && (start_req || repeat_req)) |=>
            (state == TX_LEAD_MARK && seg_left == seg_len(T_LEAD_MARK)));

    // Start wins over repeat
    assert_start_priority_R7: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && start_req) |=> !rep_mode);

    // Repeat frames never enter the data phase
    assert_repeat_no_data_R6: assert property (@(posedge clk) disable iff (rst)
        rep_mode |-> (state != TX_BIT_MARK && state != TX_BIT_SPACE
                      && state != TX_LEAD_SPACE));

    // Segment counter never idles at zero inside a frame
    assert_seg_live_R4: assert property (@(posedge clk) disable iff (rst)
        (state != TX_IDLE) |-> (seg_left != '0));

endmodule

// File: rtl/nec_ir_tx.sv
module nec_ir_tx
    import nec_tx_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int TICK_US    = 10,
    parameter int CARRIER_HZ = 38_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       repeat_req,
    input  logic [7:0] addr_in,
    input  logic [7:0] cmd_in,
    output logic       led_out,
    output logic       env_out,
    output logic       busy
);
    localparam int TICK_RAW = (CLK_HZ / 1000) * TICK_US / 1000;
    localparam int TICK_DIV = (TICK_RAW > 0) ? TICK_RAW : 1;
    localparam int CAR_RAW  = CLK_HZ / CARRIER_HZ;
    localparam int CAR_DIV  = (CAR_RAW > 1) ? CAR_RAW : 2;
    localparam int CAR_HIGH = (CAR_DIV / 3 > 0) ? CAR_DIV / 3 : 1;

    nec_payload_t payload;
    logic         tick;
    logic         env;
    logic         busy_i;

    assign payload.addr = addr_in;
    assign payload.cmd  = cmd_in;

    nec_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_i),
        .tick (tick)
    );

    nec_frame_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .start_req  (start_req),
        .repeat_req (repeat_req),
        .payload    (payload),
        .env        (env),
        .busy       (busy_i)
    );

    nec_carrier_gen #(.PERIOD(CAR_DIV), .HIGH(CAR_HIGH)) u_car (
        .clk (clk),
        .rst (rst),
        .env (env),
        .led (led_out)
    );

    assign env_out = env;
    assign busy    = busy_i;

    assert_env_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        env_out |-> busy);

endmodule

// File: tb/nec_ir_tx_test.sv
module nec_ir_tx_test;
    localparam int CLK_HZ   = 200_000;
    localparam int TICK_CYC = 2;
    localparam int CAR_P    = 5;
    localparam int CAR_H    = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic       repeat_req = 1'b0;
    logic [7:0] addr_in = 8'h00;
    logic [7:0] cmd_in = 8'h00;
    logic       led_out, env_out, busy;

    int n_checks = 0;
    int n_fail   = 0;
    logic poke_armed = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    nec_ir_tx #(.CLK_HZ(CLK_HZ), .TICK_US(10), .CARRIER_HZ(38_000)) uut (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .repeat_req (repeat_req),
        .addr_in    (addr_in),
        .cmd_in     (cmd_in),
        .led_out    (led_out),
        .env_out    (env_out),
        .busy       (busy)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Counts negedges at the given envelope level, checking LED and busy alongside
    task automatic seg(input logic level, input int ticks, input string req);
        int n = 0;
        int led_bad = 0;
        int busy_bad = 0;
        int limit = ticks * TICK_CYC + 20;
        while (env_out == level && n < limit) begin
            if (level) begin
                if (led_out != ((n % CAR_P) < CAR_H)) led_bad++;
            end else begin
                if (led_out) led_bad++;
            end
            if (!busy) busy_bad++;
            if (poke_armed && n == 3) begin
                start_req  = 1'b1;
                repeat_req = 1'b1;
                addr_in    = ~addr_in;
                cmd_in     = ~cmd_in;
            end
            if (poke_armed && n == 5) begin
                start_req  = 1'b0;
                repeat_req = 1'b0;
                poke_armed = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        check(n == ticks * TICK_CYC, req, $sformatf("segment length level %0d", level),
              n, ticks * TICK_CYC);
        check(led_bad == 0, "R9", "carrier mismatches in segment", led_bad, 0);
        check(busy_bad == 0, "R5", "busy low inside frame", busy_bad, 0);
    endtask

    task automatic accept_check(input string req);
        @(negedge clk);
        start_req  = 1'b0;
        repeat_req = 1'b0;
        check(busy == 1'b1, req, "busy after accept", int'(busy), 1);
        check(env_out == 1'b1, req, "envelope after accept", int'(env_out), 1);
    endtask

    task automatic end_check(input string req);
        check(busy == 1'b0, req, "busy at end of closing burst", int'(busy), 0);
        for (int k = 0; k < 20; k++) begin
            if (env_out || busy) begin
                check(1'b0, "R8", "activity after frame", int'(env_out), 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic data_frame(input logic [7:0] a, input logic [7:0] c,
                              input logic with_rep, input logic poke);
        logic [31:0] w;
        w = {~c, c, ~a, a};
        @(negedge clk);
        addr_in    = a;
        cmd_in     = c;
        start_req  = 1'b1;
        repeat_req = with_rep;
        accept_check(with_rep ? "R7" : "R2");
        poke_armed = poke;
        seg(1'b1, 900, "R2");
        seg(1'b0, 450, with_rep ? "R7" : "R2");
        for (int i = 0; i < 32; i++) begin
            seg(1'b1, 56, "R4");
            seg(1'b0, w[i] ? 169 : 56, poke ? "R8" : "R3");
        end
        seg(1'b1, 56, "R5");
        end_check("R5");
    endtask

    task automatic repeat_frame();
        @(negedge clk);
        repeat_req = 1'b1;
        accept_check("R6");
        seg(1'b1, 900, "R6");
        seg(1'b0, 225, "R6");
        seg(1'b1, 56, "R6");
        end_check("R6");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(env_out == 1'b0, "R1", "envelope in reset", int'(env_out), 0);
        check(led_out == 1'b0, "R1", "led in reset", int'(led_out), 0);
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && env_out == 1'b0 && led_out == 1'b0, "R1",
              "outputs after reset release", int'({busy, env_out, led_out}), 0);

        data_frame(8'h00, 8'h00, 1'b0, 1'b0);
        data_frame(8'hFF, 8'hFF, 1'b0, 1'b0);
        data_frame(8'hA5, 8'h3C, 1'b0, 1'b0);
        data_frame(8'h01, 8'h80, 1'b0, 1'b0);
        repeat_frame();
        data_frame(8'h5A, 8'hC3, 1'b0, 1'b1);
        data_frame(8'h12, 8'h34, 1'b1, 1'b0);
        repeat_frame();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule